// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox

This block lets several processors exchange short 32-bit messages through a set of hardware message queues. A sender writes a word into a queue's message register. A receiver reads the word back from the same register, and each read removes the oldest entry. Each queue has a count register that software can poll. The queue count, the user count and the queue depth are parameters. Each user owns one level-sensitive interrupt output.

Every queue produces two events. The receive event is active while the queue holds at least one message. The transmit event is active while the queue has room for another message. For each user, a 32-bit enable word selects which queue events drive that user's interrupt line. Writes to a set-enable register turn bits on and writes to a clear-enable register turn bits off. Any queue can therefore be steered to any processor. A sender may leave its transmit enable off and learn about free space by polling status instead.

The block is reached through a simple single-cycle register bus that covers a 0x200-byte window and uses byte addresses. Read data appears on `rsp_rdata` one clock after the read request. `rsp_rdata` holds that value until the next read.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty, all enable words are zero, every interrupt line is low and `rsp_rdata` is zero.
- R2: A write to the message register of queue q (byte offset 0x40 + 4*q) appends the word when the queue is not full. Reads of that register return the stored words in arrival order, one per read, and each read removes the word it returns. The data appears on `rsp_rdata` in the cycle after the read request.
- R3: A write to the message register of a queue that already holds DEPTH (default 4) words is dropped, and the stored contents and count stay unchanged.
- R4: A read of the message register of an empty queue returns zero, and the count stays zero.
- R5: The count register of queue q at 0xC0 + 4*q reads the number of stored words in bits [2:0] and a full flag in bit 16. All other bits read zero, and writes to this register are ignored.
- R6: The status register of user u at 0x100 + 0x10*u reads the same raw event word for every user. Bit 2*q is set while queue q is non-empty, and bit 2*q+1 is set while queue q is not full. Bits of queues that are not configured read zero.
- R7: Writing ones to offset +4 of user u sets those enable bits, and writing ones to offset +8 clears them. Zero bits in either write leave the enables unchanged. Reads of +4 or +8 return the current enable word, and enable bits of queues that are not configured can never be set.
- R8: Interrupt line u is high exactly when some bit is set in both the raw event word and user u's enable word. The line follows state changes in the same cycle as the register update.
- R9: Message and count registers of queues with index NUM_QUEUES or higher, and user registers of users with index NUM_USERS or higher, read zero and ignore writes.
- R10: A sender can fill and drain a queue while its transmit enable stays clear. The interrupt lines then reflect only the enabled receive events, and the status transmit bit alone reports free space.
- R11: Addresses outside the message, count and user regions, and offset +12 of each user block, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte address within the 0x200 window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read, held until the next read |
| user_irq | output | NUM_USERS | Level interrupt line per user |

## Verification
Directed sequences cover three cases. The first fills one queue past DEPTH and drains it past empty, which shows whether overflow and underflow are absorbed without corrupting order. The second sets and clears single enable bits, which separates the receive routing of a user from its transmit routing. The third uses indices just past the configured queues and users, which shows whether out-of-range decode is masked. A seeded random mix of writes, reads and enable updates across all queues and users then compares every read and every interrupt line against a bench model. This exposes state that leaks between queues or between users' enable words.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;
  localparam int SLOT_W = 4;
  localparam int FULL_BIT = 16;

  typedef enum logic [1:0] {
    UREG_STAT = 2'd0,
    UREG_SET  = 2'd1,
    UREG_CLR  = 2'd2,
    UREG_RSVD = 2'd3
  } ureg_e;

  function automatic logic in_msg_region(logic [ADDR_W-1:0] a);
    return a[8:6] == 3'b001;
  endfunction

  function automatic logic in_cnt_region(logic [ADDR_W-1:0] a);
    return a[8:6] == 3'b011;
  endfunction

  function automatic logic in_user_region(logic [ADDR_W-1:0] a);
    return a[8];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(logic [ADDR_W-1:0] a);
    return a[5:2];
  endfunction

  function automatic logic [SLOT_W-1:0] user_of(logic [ADDR_W-1:0] a);
    return a[7:4];
  endfunction

  function automatic ureg_e ureg_of(logic [ADDR_W-1:0] a);
    return ureg_e'(a[3:2]);
  endfunction

  // Event bits that exist for a given queue count: two per queue.
  function automatic logic [DATA_W-1:0] evt_mask(int nq);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int q = 0; q < nq; q++) begin
      m[2*q]   = 1'b1;
      m[2*q+1] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] count_word(int unsigned cnt, logic full);
    logic [DATA_W-1:0] w;
    w = DATA_W'(cnt & 32'h7);
    w[FULL_BIT] = full;
    return w;
  endfunction
endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= wdata;
        wr_ptr      <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop)
        rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  // R3: a push into a full queue leaves it full
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CW'(DEPTH)));
  // R4: a pop from an empty queue leaves it empty
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));
  // R2: an accepted push grows the count by one
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (count == $past(count) + 1'b1));
  // R5: count never exceeds depth
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] valid_mask,
  input  logic [DW-1:0] raw_evt,
  output logic [DW-1:0] enable,
  output logic          irq
);
  logic [DW-1:0] set_bits;
  assign set_bits = wdata & valid_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enable <= '0;
    else if (set_we) enable <= enable | set_bits;
    else if (clr_we) enable <= enable & ~wdata;
  end

  assign irq = |(raw_evt & enable);

  // R7: bits written with set are present afterwards
  a_r7_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((enable & $past(set_bits)) == $past(set_bits)));
  // R7: bits written with clear are gone afterwards
  a_r7_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((enable & $past(wdata)) == '0));
  // R8: clearing all enables silences the line
  a_r8_all_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we && (wdata == '1)) |=> !irq);
  // R7: unconfigured queue bits never enabled
  a_r7_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((enable & ~valid_mask) == '0));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int NUM_QUEUES = 8,
  parameter int NUM_USERS  = 4,
  parameter int DEPTH      = 4,
  localparam int DW        = mbx_pkg::DATA_W,
  localparam int AW        = mbx_pkg::ADDR_W,
  localparam int SW        = mbx_pkg::SLOT_W,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic [DW-1:0]        rsp_rdata,
  output logic [NUM_USERS-1:0] user_irq
);
  import mbx_pkg::*;

  localparam logic [DW-1:0] EVT_MASK = evt_mask(NUM_QUEUES);

  // decode
  logic [SW-1:0] slot, usr;
  ureg_e         ureg;
  logic          msg_hit, cnt_hit, usr_hit, slot_ok, usr_ok;
  logic          rd_req, wr_req;

  assign slot    = slot_of(req_addr);
  assign usr     = user_of(req_addr);
  assign ureg    = ureg_of(req_addr);
  assign slot_ok = (int'(slot) < NUM_QUEUES);
  assign usr_ok  = (int'(usr) < NUM_USERS);
  assign msg_hit = in_msg_region(req_addr) && slot_ok;
  assign cnt_hit = in_cnt_region(req_addr) && slot_ok;
  assign usr_hit = in_user_region(req_addr) && usr_ok;
  assign rd_req  = req_valid && !req_write;
  assign wr_req  = req_valid && req_write;

  // queues
  logic [DW-1:0] q_head  [NUM_QUEUES];
  logic [CW-1:0] q_count [NUM_QUEUES];
  logic [NUM_QUEUES-1:0] q_full, q_empty, q_push, q_pop;
  logic [DW-1:0] raw_evt;

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
    assign q_push[q] = wr_req && msg_hit && (slot == SW'(q));
    assign q_pop[q]  = rd_req && msg_hit && (slot == SW'(q));
    mbx_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(q_push[q]), .pop(q_pop[q]), .wdata(req_wdata),
      .head(q_head[q]), .count(q_count[q]),
      .full(q_full[q]), .empty(q_empty[q])
    );
  end

  always_comb begin
    raw_evt = '0;
    for (int q = 0; q < NUM_QUEUES; q++) begin
      raw_evt[2*q]   = !q_empty[q];
      raw_evt[2*q+1] = !q_full[q];
    end
  end

  // users
  logic [DW-1:0] u_enable [NUM_USERS];

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    logic sel;
    assign sel = wr_req && usr_hit && (usr == SW'(u));
    mbx_user_irq #(.DW(DW)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .set_we(sel && (ureg == UREG_SET)),
      .clr_we(sel && (ureg == UREG_CLR)),
      .wdata(req_wdata), .valid_mask(EVT_MASK), .raw_evt(raw_evt),
      .enable(u_enable[u]), .irq(user_irq[u])
    );
  end

  // read mux
  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (msg_hit || cnt_hit) begin
      for (int q = 0; q < NUM_QUEUES; q++)
        if (slot == SW'(q))
          rd_next = msg_hit ? q_head[q] : count_word(int'(q_count[q]), q_full[q]);
    end else if (usr_hit) begin
      for (int u = 0; u < NUM_USERS; u++)
        if (usr == SW'(u)) begin
          case (ureg)
            UREG_STAT:          rd_next = raw_evt;
            UREG_SET, UREG_CLR: rd_next = u_enable[u];
            default:            rd_next = '0;
          endcase
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_rdata <= '0;
    else if (rd_req) rsp_rdata <= rd_next;
  end

  // observation wires for assertions
  logic rd_empty_msg, rd_unmapped;
  assign rd_empty_msg = rd_req && msg_hit && ((q_pop & q_empty) != '0);
  assign rd_unmapped  = rd_req && !msg_hit && !cnt_hit && !usr_hit;

  // R4: empty message read returns zero
  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty_msg |=> (rsp_rdata == '0));
  // R9/R11: unmapped or unconfigured reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (rsp_rdata == '0));
  // R2: read data held between reads
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rsp_rdata));
  // R6: at most one request target selected
  a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msg_hit, cnt_hit, usr_hit}));
endmodule

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 8;
  localparam int NU = 4;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [8:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rsp_rdata;
  logic [NU-1:0] user_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] m_data [16][DP];
  int          m_cnt  [16];
  logic [31:0] m_en   [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox #(.NUM_QUEUES(NQ), .NUM_USERS(NU), .DEPTH(DP)) u_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .user_irq(user_irq)
  );

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    for (int q = 0; q < NQ; q++) begin
      if (m_cnt[q] > 0)  s[2*q] = 1'b1;
      if (m_cnt[q] < DP) s[2*q+1] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [31:0] legal_bits();
    logic [31:0] s = '0;
    for (int q = 0; q < NQ; q++) s |= 32'h3 << (2*q);
    return s;
  endfunction

  function automatic logic exp_irq(int u);
    return (exp_status() & m_en[u]) != 0;
  endfunction

  // apply a write to the model
  function automatic void model_write(logic [8:0] a, logic [31:0] d);
    int idx;
    if (a >= 9'h040 && a < 9'h080) begin
      idx = (a - 9'h040) / 4;
      if (idx < NQ && m_cnt[idx] < DP) begin
        m_data[idx][m_cnt[idx]] = d;
        m_cnt[idx]++;
      end
    end else if (a >= 9'h100) begin
      idx = (a - 9'h100) / 16;
      if (idx < NU) begin
        if (a[3:2] == 2'd1) m_en[idx] |= d & legal_bits();
        if (a[3:2] == 2'd2) m_en[idx] &= ~d;
      end
    end
  endfunction

  // expected read value, popping the model where applicable
  function automatic logic [31:0] model_read(logic [8:0] a);
    int idx;
    logic [31:0] r = '0;
    if (a >= 9'h040 && a < 9'h080) begin
      idx = (a - 9'h040) / 4;
      if (idx < NQ && m_cnt[idx] > 0) begin
        r = m_data[idx][0];
        for (int i = 0; i < DP - 1; i++) m_data[idx][i] = m_data[idx][i+1];
        m_cnt[idx]--;
      end
    end else if (a >= 9'h0C0 && a < 9'h100) begin
      idx = (a - 9'h0C0) / 4;
      if (idx < NQ) r = 32'(m_cnt[idx]) | ((m_cnt[idx] == DP) ? 32'h1_0000 : 32'h0);
    end else if (a >= 9'h100) begin
      idx = (a - 9'h100) / 16;
      if (idx < NU) begin
        case (a[3:2])
          2'd0: r = exp_status();
          2'd1, 2'd2: r = m_en[idx];
          default: r = '0;
        endcase
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_irqs(string req);
    logic [NU-1:0] e;
    for (int u = 0; u < NU; u++) e[u] = exp_irq(u);
    check(req, 32'(user_irq), 32'(e));
  endtask

  task automatic bus_write(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(string req, logic [8:0] a);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    e = model_read(a);
    @(negedge clk);
    req_valid = 1'b0;
    check(req, rsp_rdata, e);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_cnt[i] = 0; m_en[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", rsp_rdata, 32'h0);
    check("R1 irq", 32'(user_irq), 32'h0);
    rst_n = 1'b1;
    bus_read("R1 count q0", 9'h0C0);
    bus_read("R1/R6 status u0", 9'h100);
    check("R6 status tx-only value", rsp_rdata, 32'h0000_AAAA);
    bus_read("R1 enable u3", 9'h134);

    // R2/R3: fill queue 2 past depth, drain past empty
    for (int i = 0; i < DP + 1; i++) bus_write(9'h048, 32'hC0DE_0000 + i);
    bus_read("R3/R5 full count", 9'h0C8);
    check("R5 full flag word", rsp_rdata, 32'h0001_0004);
    bus_read("R6 status with full q2", 9'h110);
    for (int i = 0; i < DP; i++) bus_read("R2 fifo order", 9'h048);
    check("R2 last of four", rsp_rdata, 32'hC0DE_0003);
    bus_read("R4 empty read", 9'h048);
    bus_read("R4 count after empty read", 9'h0C8);

    // R7/R8/R10: routing
    bus_write(9'h114, 32'h0000_0010);          // user1 rx of queue 2
    check_irqs("R8 rx enabled empty queue");
    bus_write(9'h048, 32'h1234_5678);
    check_irqs("R8 rx event raises user1");
    check("R8 user1 high", 32'(user_irq[1]), 32'h1);
    bus_write(9'h104, 32'h0000_0002);          // user0 tx of queue 0
    check_irqs("R8 tx event raises user0");
    bus_write(9'h108, 32'hFFFF_FFFF);
    check_irqs("R7 clear all user0");
    bus_read("R7 enable readback set reg", 9'h114);
    bus_read("R7 enable readback clr reg", 9'h118);
    bus_write(9'h124, 32'h0000_0001);          // user2 rx of queue 0 only
    for (int i = 0; i < DP; i++) begin
      bus_write(9'h040, 32'hAB00 + i);
      check_irqs("R10 send without tx enable");
    end
    bus_read("R10 status tx bit clear when full", 9'h120);
    bus_read("R10 drain", 9'h040);
    bus_read("R10 status tx bit back", 9'h120);

    // R9/R11 out of range
    bus_write(9'h064, 32'hDEAD_BEEF);          // queue 9 message
    bus_read("R9 queue 9 message", 9'h064);
    bus_read("R9 queue 9 count", 9'h0E4);
    bus_write(9'h154, 32'hFFFF_FFFF);          // user 5 set
    bus_read("R9 user 5 enable", 9'h154);
    check_irqs("R9 no irq change");
    bus_write(9'h104, 32'hFFFF_0000);          // bits of queues 8..15
    bus_read("R7 unconfigured enable bits", 9'h104);
    bus_write(9'h010, 32'h5555_5555);
    bus_read("R11 unmapped low", 9'h010);
    bus_read("R11 unmapped mid", 9'h090);
    bus_write(9'h10C, 32'h1);
    bus_read("R11 user reserved", 9'h10C);
    bus_write(9'h0C0, 32'hFF);
    bus_read("R5 count write ignored", 9'h0C0);

    // random mix
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 3000; n++) begin
      int kind = $urandom_range(0, 9);
      int q    = $urandom_range(0, 9);
      int u    = $urandom_range(0, 4);
      logic [8:0] a;
      case (kind)
        0, 1, 2: bus_write(9'(9'h040 + 4*q), $urandom);
        3, 4, 5: bus_read("R2 random message", 9'(9'h040 + 4*q));
        6:       bus_read("R5 random count", 9'(9'h0C0 + 4*q));
        7: begin
          a = 9'(9'h100 + 16*u + 4*$urandom_range(1, 2));
          bus_write(a, $urandom & $urandom);
        end
        default: bus_read("R6 random user reg", 9'(9'h100 + 16*u + 4*$urandom_range(0, 3)));
      endcase
      check_irqs("R8 random irq");
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule